// File: doc/BRIEF.md
# Completion Delay Injector with Jitter

This block sits between a register-space responder and a packet transmit path. It takes one completion at a time, made of a context word and a data word, through a valid/ready request port. It holds the completion for a number of clock cycles and then offers it on a valid/ready response port. The point is to make completion timing look like a slower device, with or without some random spread.

Each delay is chosen at the moment the request is accepted. With `jitter_en` low, every completion waits the fixed average latency. With `jitter_en` high, the delay is the window floor plus a free-running 16-bit LFSR value reduced modulo the window width, so it always falls inside the configured floor-to-ceiling range. The latencies and the seed are elaboration parameters. When only the average is given, the floor defaults to four fifths of it and the ceiling to six fifths, and the floor is never allowed below one cycle. Only one completion is in flight at any time.

Top module: `lat_inject`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle. In the cycle after reset, `req_ready` is 1 and `rsp_valid` is 0. A completion in flight at reset is dropped and never appears on the response port.
- R2: `req_ready` is 1 only while the block is idle. A completion is captured on the rising edge where `req_valid` and `req_ready` are both 1. While a completion is held, `req_ready` stays 0, so a second request waits.
- R3: With `jitter_en` at 0 on the accepting edge, `rsp_valid` rises exactly AVG_LAT clock edges after the accepting edge.
- R4: With `jitter_en` at 1 on the accepting edge, the delay in edges is MIN_LAT + (L mod (MAX_LAT - MIN_LAT + 1)). L is the LFSR value present on the accepting edge.
- R5: In jitter mode, every delay lies between MIN_LAT and MAX_LAT inclusive. With the default parameters (AVG_LAT = 10) this window is 8 to 12.
- R6: The LFSR is 16 bits wide and loads SEED (default 0xACE1) while `rst` is high. On every later edge it shifts left by one bit and takes as its new bit 0 the XOR of bits 15, 13, 12 and 10. It advances on every clock, whether a completion is in flight or not. A zero seed is replaced by 1.
- R7: Once `rsp_valid` is 1, it stays 1 with `rsp_ctx` and `rsp_data` unchanged until an edge where `rsp_ready` is 1. After that edge `rsp_valid` is 0 and the block is idle again.
- R8: `rsp_ctx` and `rsp_data` equal the `req_ctx` and `req_data` captured on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jitter_en | input | 1 | 1 selects the random delay, 0 the fixed average delay; sampled on the accepting edge |
| req_ctx | input | CTX_W | Context word of the incoming completion |
| req_data | input | DATA_W | Data word of the incoming completion |
| req_valid | input | 1 | Incoming completion is valid |
| req_ready | output | 1 | Block is idle and can take a completion |
| rsp_ctx | output | CTX_W | Context word of the delayed completion |
| rsp_data | output | DATA_W | Data word of the delayed completion |
| rsp_valid | output | 1 | Delayed completion is on offer |
| rsp_ready | input | 1 | Downstream takes the completion |

## Verification
The fixed mode is driven with single completions and with back-to-back ones. Exact AVG_LAT timing shows that the counter is loaded and decremented correctly, and the back-to-back case shows that the second request is refused until the first has drained. The jitter mode is driven with dozens of completions at irregular gaps, and each arrival time is compared with a separate LFSR model. This tells a wrong tap, a wrong reseed or sampling the LFSR on the wrong cycle apart from a merely plausible delay; each delay is also checked against the 8-to-12 window. Response stalls of several cycles check that the held words stay stable, and a reset in the middle of a delay checks that the pending completion is dropped.

// File: rtl/lat_pkg.sv
package lat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } lat_state_e;

    localparam int LFSR_W = 16;

endpackage

// File: rtl/lat_lfsr16.sv
module lat_lfsr16 #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] value
);
    // A zero seed would lock the register at zero
    localparam logic [15:0] SEED_EFF = (SEED == 16'h0000) ? 16'h0001 : SEED;

    logic [15:0] lfsr_d, lfsr_q;
    logic        fb;

    always_comb begin
        fb     = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
        lfsr_d = {lfsr_q[14:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= SEED_EFF;
        else     lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;
endmodule

// File: rtl/lat_delay_pick.sv
module lat_delay_pick #(
    parameter int LAT_W   = 8,
    parameter int MIN_EFF = 8,
    parameter int MAX_EFF = 12,
    parameter int AVG_LAT = 10
) (
    input  logic [15:0]      lfsr,
    input  logic             jitter_en,
    output logic [LAT_W-1:0] delay
);
    localparam int SPAN = MAX_EFF - MIN_EFF + 1;

    logic [15:0] offset;

    always_comb begin
        offset = lfsr % 16'(SPAN);
        if (jitter_en) delay = LAT_W'(MIN_EFF) + LAT_W'(offset);
        else           delay = LAT_W'(AVG_LAT);
    end
endmodule

// File: rtl/lat_inject.sv
module lat_inject #(
    parameter int          CTX_W   = 16,
    parameter int          DATA_W  = 32,
    parameter int          LAT_W   = 8,
    parameter int          AVG_LAT = 10,
    parameter int          MIN_LAT = (AVG_LAT * 4) / 5,
    parameter int          MAX_LAT = (AVG_LAT * 6) / 5,
    parameter logic [15:0] SEED    = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              jitter_en,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_valid,
    output logic              req_ready,
    output logic [CTX_W-1:0]  rsp_ctx,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready
);
    import lat_pkg::*;

    localparam int MIN_EFF = (MIN_LAT < 1) ? 1 : MIN_LAT;
    localparam int MAX_EFF = (MAX_LAT < MIN_EFF) ? MIN_EFF : MAX_LAT;
    localparam int AVG_EFF = (AVG_LAT < 1) ? 1 : AVG_LAT;

    typedef struct packed {
        lat_state_e        state;
        logic [LAT_W-1:0]  cnt;
        logic [CTX_W-1:0]  ctx;
        logic [DATA_W-1:0] data;
    } lat_regs_t;

    lat_regs_t        r_d, r_q;
    logic [15:0]      lfsr_val;
    logic [LAT_W-1:0] pick;

    lat_lfsr16 #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .value (lfsr_val)
    );

    lat_delay_pick #(
        .LAT_W   (LAT_W),
        .MIN_EFF (MIN_EFF),
        .MAX_EFF (MAX_EFF),
        .AVG_LAT (AVG_EFF)
    ) u_pick (
        .lfsr      (lfsr_val),
        .jitter_en (jitter_en),
        .delay     (pick)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_WAIT;
                    r_d.cnt   = pick;
                    r_d.ctx   = req_ctx;
                    r_d.data  = req_data;
                end
            end
            ST_WAIT: begin
                if (r_q.cnt <= LAT_W'(1)) begin
                    r_d.state = ST_RESP;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt - LAT_W'(1);
                end
            end
            ST_RESP: begin
                if (rsp_ready) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.ctx   <= '0;
            r_q.data  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_valid = (r_q.state == ST_RESP);
    assign rsp_ctx   = r_q.ctx;
    assign rsp_data  = r_q.data;
endmodule

// File: rtl/lat_inject_chk.sv
module lat_inject_chk #(
    parameter int CTX_W   = 16,
    parameter int DATA_W  = 32,
    parameter int LAT_W   = 8,
    parameter int AVG_LAT = 10,
    parameter int MIN_LAT = 8,
    parameter int MAX_LAT = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              jitter_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CTX_W-1:0]  rsp_ctx,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_valid,
    input logic              rsp_ready
);
    localparam int MIN_EFF = (MIN_LAT < 1) ? 1 : MIN_LAT;
    localparam int MAX_EFF = (MAX_LAT < MIN_EFF) ? MIN_EFF : MAX_LAT;
    localparam int AVG_EFF = (AVG_LAT < 1) ? 1 : AVG_LAT;

    logic [LAT_W:0] wait_q;
    logic           busy_q, jit_q;

    // Edges counted from the accepting edge up to the edge where the response appears
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
            busy_q <= 1'b0;
            jit_q  <= 1'b0;
        end else if (req_valid && req_ready) begin
            wait_q <= (LAT_W+1)'(1);
            busy_q <= 1'b1;
            jit_q  <= jitter_en;
        end else if (busy_q && !rsp_valid) begin
            wait_q <= wait_q + (LAT_W+1)'(1);
        end else if (rsp_valid && rsp_ready) begin
            busy_q <= 1'b0;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid));

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r2_accept_closes: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ctx) && $stable(rsp_data)));

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

    a_r3_fixed_delay: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && !jit_q) |-> (wait_q == (LAT_W+1)'(AVG_EFF + 1)));

    a_r5_window: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && jit_q) |->
            (wait_q >= (LAT_W+1)'(MIN_EFF + 1) && wait_q <= (LAT_W+1)'(MAX_EFF + 1)));
endmodule

bind lat_inject lat_inject_chk #(
    .CTX_W   (CTX_W),
    .DATA_W  (DATA_W),
    .LAT_W   (LAT_W),
    .AVG_LAT (AVG_LAT),
    .MIN_LAT (MIN_LAT),
    .MAX_LAT (MAX_LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .jitter_en (jitter_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_ctx   (rsp_ctx),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready)
);

// File: tb/lat_inject_test.sv
`timescale 1ns/1ps
module lat_inject_test;
    localparam int AVG   = 10;
    localparam int MIN_E = (AVG * 4) / 5;
    localparam int MAX_E = (AVG * 6) / 5;
    localparam int SPAN  = MAX_E - MIN_E + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        jitter_en = 1'b0;
    logic [15:0] req_ctx = '0;
    logic [31:0] req_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] rsp_ctx;
    logic [31:0] rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int stall_cfg = 0;
    bit done = 1'b0;
    logic [15:0] model;

    typedef struct {
        logic [15:0] c;
        logic [31:0] d;
        int          exp;
        int          acc;
        bit          jit;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    lat_inject #(.AVG_LAT(AVG)) uut (
        .clk(clk), .rst(rst), .jitter_en(jitter_en),
        .req_ctx(req_ctx), .req_data(req_data), .req_valid(req_valid), .req_ready(req_ready),
        .rsp_ctx(rsp_ctx), .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready)
    );

    function automatic logic [15:0] lfsr_next(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Independent model of the LFSR (R6) and a cycle counter
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        model <= rst ? 16'hACE1 : lfsr_next(model);
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(logic [15:0] c, logic [31:0] d);
        int dly;
        @(negedge clk);
        req_valid = 1'b1;
        req_ctx   = c;
        req_data  = d;
        while (!req_ready) @(negedge clk);
        dly = jitter_en ? (MIN_E + int'(model % 16'(SPAN))) : AVG;
        q.push_back('{c: c, d: d, exp: cyc + 1 + dly, acc: cyc + 1, jit: jitter_en});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pops expected items as responses appear
    initial begin
        item_t cur;
        bit holding = 1'b0;
        int stall_left = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                holding   = 1'b0;
                rsp_ready = 1'b0;
            end else if (rsp_valid) begin
                chk(req_ready == 1'b0, "R2", "req_ready while holding", req_ready, 0);
                if (!holding) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R1", "unexpected response", 1, 0);
                        cur = '{c: rsp_ctx, d: rsp_data, exp: cyc, acc: cyc, jit: 1'b0};
                    end else begin
                        cur = q.pop_front();
                        chk(rsp_ctx == cur.c, "R8", "ctx", rsp_ctx, cur.c);
                        chk(rsp_data == cur.d, "R8", "data", rsp_data, cur.d);
                        if (cur.jit) begin
                            chk(cyc == cur.exp, "R4 R6", "jitter arrival cycle", cyc, cur.exp);
                            chk((cyc - cur.acc) >= MIN_E && (cyc - cur.acc) <= MAX_E,
                                "R5", "jitter delay", cyc - cur.acc, MIN_E);
                        end else begin
                            chk(cyc == cur.exp, "R3", "fixed arrival cycle", cyc, cur.exp);
                        end
                    end
                    holding    = 1'b1;
                    stall_left = stall_cfg;
                end else begin
                    chk(rsp_ctx == cur.c && rsp_data == cur.d, "R7", "held data stable",
                        rsp_data, cur.d);
                end
                if (stall_left == 0) begin
                    rsp_ready = 1'b1;
                    holding   = 1'b0;
                end else begin
                    rsp_ready = 1'b0;
                    stall_left--;
                end
            end else begin
                rsp_ready = 1'b0;
            end
        end
    end

    task automatic drain();
        int guard = 0;
        while ((q.size() != 0 || rsp_valid) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

        // R3: fixed delay, single completions
        jitter_en = 1'b0;
        send(16'h0011, 32'hA5A5_0001);
        drain();
        send(16'h0022, 32'h5A5A_0002);
        send(16'h0033, 32'hFFFF_0003);
        drain();

        // R2 / R7: back-to-back under response stalls
        stall_cfg = 3;
        send(16'h0101, 32'h1234_5678);
        fork
            send(16'h0202, 32'h8765_4321);
            begin
                @(negedge clk);
                chk(req_ready == 1'b0, "R2", "second request refused", req_ready, 0);
            end
        join
        drain();

        // R4 / R5 / R6: jitter mode at irregular gaps
        stall_cfg = 0;
        jitter_en = 1'b1;
        for (int i = 0; i < 24; i++) begin
            send(16'(16'h1000 + i), 32'hC0DE_0000 + 32'(i * 7));
            repeat (i % 4) @(negedge clk);
        end
        drain();

        stall_cfg = 2;
        for (int i = 0; i < 6; i++) send(16'(16'h2000 + i), 32'(i) ^ 32'hDEAD_BEEF);
        drain();
        stall_cfg = 0;

        // R1: reset in the middle of a delay drops the completion
        send(16'h3333, 32'h3333_3333);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after mid-flight reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after mid-flight reset", rsp_valid, 0);
        repeat (AVG + 8) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "dropped completion stays gone", rsp_valid, 0);

        // R6: LFSR reseeded, jitter continues to match the model
        for (int i = 0; i < 8; i++) begin
            send(16'(16'h4000 + i), 32'hBEEF_0000 + 32'(i));
            repeat (i % 3) @(negedge clk);
        end
        drain();
        chk(q.size() == 0, "R7", "all completions delivered", q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule